// File: doc/BRIEF.md
# Partitioned Vector Dot-Product Accelerator

This block computes one element of a matrix product as the signed dot product of a row vector and a column vector. It is built from identical slices. Each slice holds a 16-element piece of the row and of the column and has four multiply-accumulate units. With the default four slices the block handles vectors of up to 64 elements. Slices that lie wholly beyond the programmed length do not contribute to the result.

Software works through one register port. It fills the row buffer and a column buffer, writes the vector length, and sets the go bit. It then polls the status word until the done flag is set and reads the 40-bit result from one of four output slots. There are two column buffers. Column writes always land in the buffer that the next job will use, so software can load the next column while the current dot product is still running.

The schedule is fixed at six cycles. In cycles one to four, each MAC takes one of its four element pairs in turn through an input multiplexer. In cycle five, an adder tree inside each slice sums the four MAC results. In cycle six, the slice sums are added and the total is written to the output slot.

Top module: `dot_accel`

## Requirements
- R1: After reset the status word reads 0 (bit0 busy, bit1 done, bit2 next column bank), the length register at address 0x01 reads 0, and every output slot (addresses 0xC0 to 0xC3) reads 0.
- R2: The value stored in the output slot equals the sum over i < L of row[i]*col[i]. Elements are 16-bit signed, and rows are written at 0x40+i and columns at 0x80+i. L is the length that was in the length register (0x01, bits 6:0) at the accepted start. Elements at index L or above have no effect.
- R3: A write to address 0x00 with bit0 set, while idle, starts a job. The done flag and the result become visible after exactly six clock edges. A status read returns the state as it was before its own capturing edge, so exactly six consecutive polls report not done.
- R4: A write to address 0x00 while busy is ignored. It does not change the completion timing, the output slot being written, or the column bank.
- R5: Done is cleared by an accepted start and stays set while idle until the next accepted start.
- R6: Column writes go to the bank shown in status bit2, which is the bank the next accepted start computes from. The bank toggles once per accepted start. Column writes made during a job do not alter that job's result.
- R7: The result is written to the output slot given by bits 5:4 of the start write. The other slots keep their values.
- R8: Accumulation is 40-bit signed with no saturation. Extreme operands (-32768 times -32768, and -32768 times 32767, over 64 elements) give the exact result.
- R9: A length of 0 gives a result of 0. A length above 64 is treated as 64.
- R10: Reads have a fixed one-cycle latency: rdData shows the addressed word after the clock edge at which rdEn was sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| addr | input | 8 | Word address: bits 7:6 select region (0 registers, 1 row, 2 column, 3 output), bits 5:0 index |
| wrData | input | 16 | Write data |
| rdData | output | 40 | Read data, registered |

## Verification
The dot product is tried with pseudo-random signed data at lengths 16, 37 and 64. Length 16 shows that only the first slice is summed. Length 37 exercises masking inside a partly used slice, with non-zero data past the end. Length 64 combines all four slices. Lengths 0 and 100 check the limits of the length field. Uniform extreme operands separate true 40-bit sign handling from truncation or saturation. A column prefetch issued during a running job, followed by a job with no reload, tells the two column banks apart.

// File: rtl/dotacc_pkg.sv
package dotacc_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic macEn;
    logic macFirst;
    logic treeEn;
    logic sumEn;
  } dot_strobe_t;

  typedef enum logic [1:0] {
    REGION_REG = 2'd0,
    REGION_ROW = 2'd1,
    REGION_COL = 2'd2,
    REGION_OUT = 2'd3
  } region_e;

  localparam int CTRL_IDX = 0;
  localparam int LEN_IDX  = 1;
  localparam int GO_BIT   = 0;
  localparam int SLOT_LSB = 4;
endpackage

// File: rtl/dot_slice.sv
module dot_slice
  import dotacc_pkg::*;
#(
  parameter int ELEM_W    = 16,
  parameter int ACC_W     = 40,
  parameter int SLICE_LEN = 16,
  parameter int NUM_MACS  = 4,
  localparam int PAIRS    = SLICE_LEN / NUM_MACS,
  localparam int PH_W     = (PAIRS > 1) ? $clog2(PAIRS) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  dot_strobe_t                   strb,
  input  logic [PH_W-1:0]               phase,
  input  logic [SLICE_LEN*ELEM_W-1:0]   rowSeg,
  input  logic [SLICE_LEN*ELEM_W-1:0]   colSeg,
  input  logic [SLICE_LEN-1:0]          keep,
  output logic signed [ACC_W-1:0]       sliceSum
);
  logic signed [ACC_W-1:0] prod [NUM_MACS];
  logic signed [ACC_W-1:0] acc  [NUM_MACS];
  logic signed [ACC_W-1:0] treeSum;

  // input multiplexer: MAC m takes element m*PAIRS + phase
  always_comb begin
    logic signed [ELEM_W-1:0]   a;
    logic signed [ELEM_W-1:0]   b;
    logic signed [2*ELEM_W-1:0] full;
    int idx;
    for (int m = 0; m < NUM_MACS; m++) begin
      idx  = m * PAIRS + int'(phase);
      a    = signed'(rowSeg[idx*ELEM_W +: ELEM_W]);
      b    = signed'(colSeg[idx*ELEM_W +: ELEM_W]);
      full = a * b;
      prod[m] = keep[idx] ? ACC_W'(full) : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int m = 0; m < NUM_MACS; m++) acc[m] <= '0;
    end else if (strb.macEn) begin
      for (int m = 0; m < NUM_MACS; m++)
        acc[m] <= strb.macFirst ? prod[m] : acc[m] + prod[m];
    end
  end

  always_comb begin
    treeSum = '0;
    for (int m = 0; m < NUM_MACS; m++) treeSum = treeSum + acc[m];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           sliceSum <= '0;
    else if (strb.treeEn) sliceSum <= treeSum;
  end

  // R3: the first accumulation step always uses element pair zero
  assert_mac_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    strb.macFirst |-> (phase == '0));
endmodule

// File: rtl/dot_ctrl.sv
module dot_ctrl
  import dotacc_pkg::*;
#(
  parameter int ELEM_W    = 16,
  parameter int VEC_LEN   = 64,
  parameter int PAIRS     = 4,
  parameter int OUT_DEPTH = 4,
  localparam int LEN_W     = $clog2(VEC_LEN) + 1,
  localparam int PH_W      = (PAIRS > 1) ? $clog2(PAIRS) : 1,
  localparam int SLOT_W    = (OUT_DEPTH > 1) ? $clog2(OUT_DEPTH) : 1,
  localparam int LAST_STEP = PAIRS + 1,
  localparam int STEP_W    = $clog2(LAST_STEP + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrlWr,
  input  logic              lenWr,
  input  logic [ELEM_W-1:0] wrData,
  output dot_strobe_t       strb,
  output logic [PH_W-1:0]   phase,
  output logic              busy,
  output logic              done,
  output logic              nextBank,
  output logic              computeBank,
  output logic [LEN_W-1:0]  lenReg,
  output logic [LEN_W-1:0]  lenAct,
  output logic [SLOT_W-1:0] slotAct
);
  logic [STEP_W-1:0] step;
  logic              startAcc;

  assign startAcc = ctrlWr && wrData[GO_BIT] && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lenReg <= '0;
    else if (lenWr) lenReg <= wrData[LEN_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      done        <= 1'b0;
      step        <= '0;
      nextBank    <= 1'b0;
      computeBank <= 1'b0;
      lenAct      <= '0;
      slotAct     <= '0;
    end else if (startAcc) begin
      busy        <= 1'b1;
      done        <= 1'b0;
      step        <= '0;
      nextBank    <= ~nextBank;
      computeBank <= nextBank;
      lenAct      <= (lenReg > LEN_W'(VEC_LEN)) ? LEN_W'(VEC_LEN) : lenReg;
      slotAct     <= wrData[SLOT_LSB +: SLOT_W];
    end else if (busy) begin
      step <= step + 1'b1;
      if (step == STEP_W'(LAST_STEP)) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end

  always_comb begin
    strb.macEn    = busy && (step < STEP_W'(PAIRS));
    strb.macFirst = busy && (step == '0);
    strb.treeEn   = busy && (step == STEP_W'(PAIRS));
    strb.sumEn    = busy && (step == STEP_W'(LAST_STEP));
    phase         = step[PH_W-1:0];
  end

  // R5: an accepted start clears done and raises busy
  assert_start_clears_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    startAcc |=> (busy && !done));
  // R5: done holds until the next accepted start
  assert_done_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !startAcc) |=> done);
  // R6: bank toggles on every accepted start
  assert_bank_swap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    startAcc |=> (nextBank != $past(nextBank)));
  assert_bank_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !startAcc |=> $stable(nextBank));
  // R4: writes while busy leave the job's slot and bank untouched
  assert_busy_ignore_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(slotAct) && $stable(computeBank)));
  // R3: completion follows the final summing cycle
  assert_done_after_sum_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done && $past(strb.sumEn)));
endmodule

// File: rtl/dot_datapath.sv
module dot_datapath
  import dotacc_pkg::*;
#(
  parameter int ELEM_W     = 16,
  parameter int ACC_W      = 40,
  parameter int SLICE_LEN  = 16,
  parameter int NUM_SLICES = 4,
  parameter int NUM_MACS   = 4,
  parameter int OUT_DEPTH  = 4,
  localparam int VEC_LEN   = SLICE_LEN * NUM_SLICES,
  localparam int IDX_W     = $clog2(VEC_LEN),
  localparam int LEN_W     = IDX_W + 1,
  localparam int PAIRS     = SLICE_LEN / NUM_MACS,
  localparam int PH_W      = (PAIRS > 1) ? $clog2(PAIRS) : 1,
  localparam int SLOT_W    = (OUT_DEPTH > 1) ? $clog2(OUT_DEPTH) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rowWr,
  input  logic                    colWr,
  input  logic [IDX_W-1:0]        wrIdx,
  input  logic [ELEM_W-1:0]       wrData,
  input  logic                    nextBank,
  input  logic                    computeBank,
  input  logic [LEN_W-1:0]        lenAct,
  input  dot_strobe_t             strb,
  input  logic [PH_W-1:0]         phase,
  input  logic [SLOT_W-1:0]       slotAct,
  input  logic [SLOT_W-1:0]       rdSlot,
  output logic signed [ACC_W-1:0] outWord
);
  logic [ELEM_W-1:0] rowMem [VEC_LEN];
  logic [ELEM_W-1:0] colMem [2][VEC_LEN];
  logic signed [ACC_W-1:0] sliceSum [NUM_SLICES];
  logic [NUM_SLICES-1:0]   sliceActive;
  logic signed [ACC_W-1:0] total;
  logic signed [ACC_W-1:0] outBuf [OUT_DEPTH];

  always_ff @(posedge clk) begin
    if (rowWr) rowMem[wrIdx] <= wrData;
    if (colWr) colMem[nextBank][wrIdx] <= wrData;
  end

  for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
    logic [SLICE_LEN*ELEM_W-1:0] rowSeg;
    logic [SLICE_LEN*ELEM_W-1:0] colSeg;
    logic [SLICE_LEN-1:0]        keep;

    always_comb begin
      for (int k = 0; k < SLICE_LEN; k++) begin
        rowSeg[k*ELEM_W +: ELEM_W] = rowMem[s*SLICE_LEN + k];
        colSeg[k*ELEM_W +: ELEM_W] = colMem[computeBank][s*SLICE_LEN + k];
        keep[k] = (32'(s*SLICE_LEN + k) < 32'(lenAct));
      end
    end

    assign sliceActive[s] = (32'(s*SLICE_LEN) < 32'(lenAct));

    dot_slice #(
      .ELEM_W(ELEM_W), .ACC_W(ACC_W), .SLICE_LEN(SLICE_LEN), .NUM_MACS(NUM_MACS)
    ) slice_i (
      .clk(clk), .rst_n(rst_n), .strb(strb), .phase(phase),
      .rowSeg(rowSeg), .colSeg(colSeg), .keep(keep), .sliceSum(sliceSum[s])
    );
  end

  always_comb begin
    total = '0;
    for (int s = 0; s < NUM_SLICES; s++)
      if (sliceActive[s]) total = total + sliceSum[s];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int d = 0; d < OUT_DEPTH; d++) outBuf[d] <= '0;
    end else if (strb.sumEn) begin
      outBuf[slotAct] <= total;
    end
  end

  assign outWord = outBuf[rdSlot];

  // R3: the schedule phases never overlap
  assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb.macEn, strb.treeEn, strb.sumEn}));
  // R3: the cross-slice sum directly follows the in-slice adder tree
  assert_tree_then_sum_R3: assert property (@(posedge clk) disable iff (!rst_n)
    strb.sumEn |-> $past(strb.treeEn));
endmodule

// File: rtl/dot_accel.sv
module dot_accel
  import dotacc_pkg::*;
#(
  parameter int ELEM_W     = 16,
  parameter int ACC_W      = 40,
  parameter int SLICE_LEN  = 16,
  parameter int NUM_SLICES = 4,
  parameter int NUM_MACS   = 4,
  parameter int OUT_DEPTH  = 4,
  localparam int VEC_LEN   = SLICE_LEN * NUM_SLICES,
  localparam int IDX_W     = $clog2(VEC_LEN),
  localparam int LEN_W     = IDX_W + 1,
  localparam int ADDR_W    = IDX_W + 2,
  localparam int PAIRS     = SLICE_LEN / NUM_MACS,
  localparam int PH_W      = (PAIRS > 1) ? $clog2(PAIRS) : 1,
  localparam int SLOT_W    = (OUT_DEPTH > 1) ? $clog2(OUT_DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ELEM_W-1:0] wrData,
  output logic [ACC_W-1:0]  rdData
);
  region_e           region;
  logic [IDX_W-1:0]  idx;
  logic              ctrlWr, lenWr, rowWr, colWr;
  dot_strobe_t       strb;
  logic [PH_W-1:0]   phase;
  logic              busy, done, nextBank, computeBank;
  logic [LEN_W-1:0]  lenReg, lenAct;
  logic [SLOT_W-1:0] slotAct;
  logic signed [ACC_W-1:0] outWord;

  assign region = region_e'(addr[ADDR_W-1 -: 2]);
  assign idx    = addr[IDX_W-1:0];
  assign ctrlWr = wrEn && (region == REGION_REG) && (idx == IDX_W'(CTRL_IDX));
  assign lenWr  = wrEn && (region == REGION_REG) && (idx == IDX_W'(LEN_IDX));
  assign rowWr  = wrEn && (region == REGION_ROW);
  assign colWr  = wrEn && (region == REGION_COL);

  dot_ctrl #(
    .ELEM_W(ELEM_W), .VEC_LEN(VEC_LEN), .PAIRS(PAIRS), .OUT_DEPTH(OUT_DEPTH)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n), .ctrlWr(ctrlWr), .lenWr(lenWr), .wrData(wrData),
    .strb(strb), .phase(phase), .busy(busy), .done(done), .nextBank(nextBank),
    .computeBank(computeBank), .lenReg(lenReg), .lenAct(lenAct), .slotAct(slotAct)
  );

  dot_datapath #(
    .ELEM_W(ELEM_W), .ACC_W(ACC_W), .SLICE_LEN(SLICE_LEN),
    .NUM_SLICES(NUM_SLICES), .NUM_MACS(NUM_MACS), .OUT_DEPTH(OUT_DEPTH)
  ) dp_i (
    .clk(clk), .rst_n(rst_n), .rowWr(rowWr), .colWr(colWr), .wrIdx(idx),
    .wrData(wrData), .nextBank(nextBank), .computeBank(computeBank),
    .lenAct(lenAct), .strb(strb), .phase(phase), .slotAct(slotAct),
    .rdSlot(idx[SLOT_W-1:0]), .outWord(outWord)
  );

  // R10: registered read port, one cycle of latency
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdData <= '0;
    end else if (rdEn) begin
      unique case (region)
        REGION_REG: begin
          if (idx == IDX_W'(CTRL_IDX))     rdData <= ACC_W'({nextBank, done, busy});
          else if (idx == IDX_W'(LEN_IDX)) rdData <= ACC_W'(lenReg);
          else                             rdData <= '0;
        end
        REGION_OUT: rdData <= (32'(idx) < OUT_DEPTH) ? outWord : '0;
        default:    rdData <= '0;
      endcase
    end
  end
endmodule

// File: tb/dot_accel_tb_top.sv
`timescale 1ns/1ps
module dot_accel_tb_top;
  localparam int VEC = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [7:0]  addr = '0;
  logic [15:0] wrData = '0;
  logic [39:0] rdData;

  always #2 clk = ~clk;

  dot_accel dut_i (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .rdData(rdData)
  );

  int checks = 0;
  int errors = 0;
  int rowM [VEC];
  int colM [2][VEC];
  int bankM = 0;
  longint slotM [4];

  typedef struct {
    int     slot;
    longint value;
    string  tag;
  } exp_t;
  exp_t expQ [$];

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); wrEn = 1'b1; addr = a; wrData = d;
    @(posedge clk); #1 wrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [39:0] v);
    @(negedge clk); rdEn = 1'b1; addr = a;
    @(posedge clk); #1 rdEn = 1'b0; v = rdData;
  endtask

  function automatic int pat(input int i, input int seed);
    return ((i * 7919 + seed * 104729 + i * i * 31) % 65536) - 32768;
  endfunction

  function automatic longint model(input int len, input int bank);
    longint s = 0;
    int n = (len > VEC) ? VEC : len;
    for (int i = 0; i < n; i++) s += longint'(rowM[i]) * longint'(colM[bank][i]);
    return s;
  endfunction

  task automatic loadRow(input int seed, input bit flat, input int flatVal);
    for (int i = 0; i < VEC; i++) begin
      rowM[i] = flat ? flatVal : pat(i, seed);
      wr(8'h40 | 8'(i), 16'(rowM[i]));
    end
  endtask

  // column writes land in the bank the next start will use (R6)
  task automatic loadColNext(input int seed, input bit flat, input int flatVal);
    for (int i = 0; i < VEC; i++) begin
      colM[bankM][i] = flat ? flatVal : pat(i, seed + 17);
      wr(8'h80 | 8'(i), 16'(colM[bankM][i]));
    end
  endtask

  // driver: pushes the expected item, starts, polls
  task automatic runJob(input int len, input int slot, input string tag,
                        input bit injectGo, input int injSlot, input int prefetchSeed);
    logic [39:0] v;
    int busyPolls = 0;
    expQ.push_back('{slot, model(len, bankM), tag});
    wr(8'h01, 16'(len));
    wr(8'h00, 16'(1 | (slot << 4)));
    bankM ^= 1;
    if (prefetchSeed > 0) begin
      loadColNext(prefetchSeed, 1'b0, 0);
      rd(8'h00, v);
      chk(v[1] == 1'b1, "R6 done after prefetch", longint'(v[1]), 1);
    end else begin
      for (int j = 0; j < 20; j++) begin
        if (injectGo && j == 2) begin
          wr(8'h00, 16'(1 | (injSlot << 4)));
          busyPolls++;
        end else begin
          rd(8'h00, v);
          if (j == 0) chk(v[1] == 1'b0 && v[0] == 1'b1, "R5 start clears done", longint'(v[1:0]), 1);
          if (v[1]) break;
          busyPolls++;
        end
      end
      chk(busyPolls == 6, injectGo ? "R4 busy start keeps timing" : "R3 six-cycle schedule",
          busyPolls, 6);
    end
    chk(v[2] == bankM[0], "R6 bank toggles once per start", longint'(v[2]), bankM);
  endtask

  // monitor: pops expected items and compares against output slots
  task automatic collect();
    logic [39:0] v;
    exp_t e;
    while (expQ.size() > 0) begin
      e = expQ.pop_front();
      rd(8'hC0 | 8'(e.slot), v);
      chk(v == e.value[39:0], e.tag, longint'(signed'(v)), e.value);
      slotM[e.slot] = e.value;
    end
  endtask

  task automatic checkSlot(input int s, input string tag);
    logic [39:0] v;
    rd(8'hC0 | 8'(s), v);
    chk(v == slotM[s][39:0], tag, longint'(signed'(v)), slotM[s]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [39:0] v;
    for (int s = 0; s < 4; s++) slotM[s] = 0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(8'h00, v); chk(v == 0, "R1 status after reset", longint'(v), 0);
    rd(8'h01, v); chk(v == 0, "R1 length after reset", longint'(v), 0);
    for (int s = 0; s < 4; s++) checkSlot(s, "R1 output slot after reset");

    // R10 read latency: length readback the cycle after a write
    wr(8'h01, 16'd21);
    rd(8'h01, v); chk(v == 21, "R10 length readback", longint'(v), 21);

    // R2 single slice
    loadRow(1, 1'b0, 0);
    loadColNext(2, 1'b0, 0);
    runJob(16, 0, "R2 len16 one slice", 1'b0, 0, 0);
    collect();

    // R2 all slices
    loadColNext(3, 1'b0, 0);
    runJob(64, 1, "R2 len64 four slices", 1'b0, 0, 0);
    collect();

    // R2 partial slice masking
    loadColNext(4, 1'b0, 0);
    runJob(37, 2, "R2 len37 masked tail", 1'b0, 0, 0);
    collect();

    // R9 zero length, R7 other slots untouched
    loadColNext(5, 1'b0, 0);
    runJob(0, 3, "R9 len0 gives zero", 1'b0, 0, 0);
    collect();
    checkSlot(0, "R7 slot0 kept");
    checkSlot(1, "R7 slot1 kept");

    // R9 length above 64 clamps
    loadColNext(6, 1'b0, 0);
    runJob(100, 0, "R9 len100 as 64", 1'b0, 0, 0);
    collect();

    // R5 done persists while idle
    repeat (20) @(posedge clk);
    rd(8'h00, v); chk(v[1] == 1'b1, "R5 done holds idle", longint'(v[1]), 1);

    // R8 extreme operands
    loadRow(0, 1'b1, -32768);
    loadColNext(0, 1'b1, -32768);
    runJob(64, 1, "R8 max positive", 1'b0, 0, 0);
    collect();
    loadColNext(0, 1'b1, 32767);
    runJob(64, 2, "R8 large negative", 1'b0, 0, 0);
    collect();

    // R4 start while busy ignored
    loadRow(9, 1'b0, 0);
    loadColNext(10, 1'b0, 0);
    runJob(64, 1, "R4 result in original slot", 1'b1, 3, 0);
    collect();
    checkSlot(3, "R4 injected slot untouched");

    // R6 prefetch during compute, then compute from prefetched bank
    loadColNext(11, 1'b0, 0);
    runJob(48, 0, "R6 prefetch leaves running job", 1'b0, 0, 12);
    collect();
    runJob(64, 2, "R6 prefetched column used", 1'b0, 0, 0);
    collect();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule